// File: doc/BRIEF.md
# I2C Dual-Role Bus Sequencer

This block is the control sequencer of an I2C bus port that can act either as the bus master or as an addressed target. After reset it listens as a target. A one-cycle start request, given while the bus is idle, turns it into a master. As master it generates a start condition, shifts out a 7-bit address with the R/W bit, runs one data byte in the direction that bit selects, issues a stop, and then falls back to target listening without further requests. As a target it watches the bus for a start condition and compares the incoming address with its own. On a match it acknowledges and moves one byte. It then waits for the stop that closes the transfer.

The SCL and SDA inputs are expected to be synchronized and filtered already. The two line outputs are pull-low enables for open-drain pads. Master bit timing comes from a fixed divider: every bit lasts four quarter periods of `QTR_DIV` clock cycles each. Target-side timing follows the edges of SCL as driven by the remote master. A single state register serves both roles.

Top module: `i2c_role_seq`

States:
- Target side: `ST_S_IDLE` (listening), `ST_S_ADDR` (address shift-in), `ST_S_AACK` (address acknowledge), `ST_S_RX` / `ST_S_RACK` (byte in, then acknowledge), `ST_S_TX` / `ST_S_TACK` (byte out, then sample the master's acknowledge), `ST_S_WSTOP` (wait for stop), `ST_S_SKIP` (not addressed, wait for stop).
- Master side: `ST_M_START`, `ST_M_ADDR`, `ST_M_AACK`, `ST_M_DATA`, `ST_M_DACK`, `ST_M_STOP`.

Transitions:
- Listening to master:
  - `ST_S_IDLE`→`ST_M_START` on an accepted request.
  - `ST_M_START`→`ST_M_ADDR`→`ST_M_AACK`.
  - `ST_M_AACK`→`ST_M_DATA` on ACK, or →`ST_M_STOP` on NACK.
  - `ST_M_DATA`→`ST_M_DACK`→`ST_M_STOP`→`ST_S_IDLE`.
- Target side:
  - `ST_S_IDLE`→`ST_S_ADDR` on a bus start.
  - `ST_S_ADDR`→`ST_S_AACK` on a match, or →`ST_S_SKIP` otherwise.
  - `ST_S_AACK`→`ST_S_RX` or →`ST_S_TX`, chosen by R/W.
  - `ST_S_RX`→`ST_S_RACK`→`ST_S_WSTOP`.
  - `ST_S_TX`→`ST_S_TACK`→`ST_S_WSTOP`.
  - Any active target state returns to `ST_S_IDLE` on a stop, and to `ST_S_ADDR` on a repeated start.

## Requirements
- R1: After reset the block is in target mode: `is_master`=0, both pull-low enables are 0, `bus_busy`=0 and `nack_err`=0.
- R2: A `start_req` pulse taken in target idle while `bus_busy`=0 makes `is_master` read 1 in the following cycle, and the block pulls SDA low while SCL is still released (a start condition).
- R3: When the master stop condition completes, `is_master` returns to 0 with no further input, and `xfer_done` pulses for one cycle in that same cycle.
- R4: The master frame is: start, the byte {`tgt_addr`[6:0], `rd_nwr`} sent MSB first, an acknowledge slot, one data byte, an acknowledge slot, then a stop.
- R5: With `rd_nwr`=0 the master sends `wr_byte` MSB first. With `rd_nwr`=1 it shifts the target's byte into `rx_byte` and answers it with NACK (SDA released).
- R6: A `start_req` is ignored while `bus_busy`=1: `is_master` stays 0.
- R7: If SDA reads high in the address or data acknowledge slot of a master write, the master skips any remaining data, issues a stop and sets `nack_err`. `nack_err` holds until the next accepted start request clears it.
- R8: The line outputs are pull-low enables only. With neither side pulling, both bus lines read 1 through the pull-up.
- R9: A start (SDA falls while SCL is high) sets `bus_busy`. A stop (SDA rises while SCL is high) clears it.
- R10: In target mode, an address byte whose upper seven bits equal `own_addr` is acknowledged (SDA pulled low in the ninth clock). Any other address gets no acknowledge and no `xfer_done`, and the block ignores the bus until a stop.
- R11: In an addressed target write (R/W=0), the byte received is acknowledged, appears on `rx_byte`, and `xfer_done` pulses once when the closing stop is seen.
- R12: In an addressed target read (R/W=1), the block sends `slv_tx_byte` MSB first and then releases SDA. `xfer_done` pulses once on the closing stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle request to become master and run a transfer |
| rd_nwr | input | 1 | Master direction: 0 write, 1 read |
| tgt_addr | input | 7 | Address of the remote target in master mode |
| wr_byte | input | 8 | Byte sent by a master write |
| own_addr | input | 7 | Address this block answers to as a target |
| slv_tx_byte | input | 8 | Byte returned when read as a target |
| scl_in | input | 1 | Filtered SCL line level |
| sda_in | input | 1 | Filtered SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| is_master | output | 1 | Block currently owns the bus as master |
| bus_busy | output | 1 | Start seen without a later stop |
| xfer_done | output | 1 | One-cycle pulse at the end of a completed transfer |
| nack_err | output | 1 | Master saw a NACK in the last transfer |
| rx_byte | output | 8 | Last byte received (master read or target write) |

## Verification
The bench builds the block with `QTR_DIV` = 4, so a master bit takes sixteen clock cycles. This keeps a whole master frame short enough that many randomized frames, together with the directed NACK cases, fit in the run. The remote master driven by the bench holds each SCL half-period for ten clock cycles. That leaves room for the target side's edge-detect latency before any sample is taken. The own address is fixed and the random addresses are mostly aimed at it, so both the acknowledge path and the ignore-until-stop path recur.

// File: rtl/i2c_role_pkg.sv
package i2c_role_pkg;

    localparam int BYTE_W = 8;
    localparam int ADR_W  = 7;
    localparam int CNT_W  = $clog2(BYTE_W) + 1;

    typedef enum logic [4:0] {
        ST_S_IDLE,
        ST_S_ADDR,
        ST_S_AACK,
        ST_S_RX,
        ST_S_RACK,
        ST_S_TX,
        ST_S_TACK,
        ST_S_WSTOP,
        ST_S_SKIP,
        ST_M_START,
        ST_M_ADDR,
        ST_M_AACK,
        ST_M_DATA,
        ST_M_DACK,
        ST_M_STOP
    } role_state_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic busy;
    } bus_evt_t;

    function automatic logic in_master(input role_state_e s);
        return (s == ST_M_START) || (s == ST_M_ADDR) || (s == ST_M_AACK) ||
               (s == ST_M_DATA)  || (s == ST_M_DACK) || (s == ST_M_STOP);
    endfunction

endpackage

// File: rtl/i2c_line_watch.sv
module i2c_line_watch
    import i2c_role_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_i,
    input  logic     sda_i,
    output bus_evt_t evt
);

    logic scl_d;
    logic sda_d;
    logic busy_q;
    logic start_c;
    logic stop_c;

    // Conditions only count when SCL is high on both samples.
    assign start_c = scl_i && scl_d && sda_d && !sda_i;
    assign stop_c  = scl_i && scl_d && !sda_d && sda_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d  <= 1'b1;
            sda_d  <= 1'b1;
            busy_q <= 1'b0;
        end else begin
            scl_d <= scl_i;
            sda_d <= sda_i;
            if (start_c) begin
                busy_q <= 1'b1;
            end else if (stop_c) begin
                busy_q <= 1'b0;
            end
        end
    end

    always_comb begin
        evt.start    = start_c;
        evt.stop     = stop_c;
        evt.scl_rise = scl_i && !scl_d;
        evt.scl_fall = !scl_i && scl_d;
        evt.busy     = busy_q;
    end

endmodule

// File: rtl/i2c_qtr_tick.sv
module i2c_qtr_tick #(
    parameter int DIV = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

endmodule

// File: rtl/i2c_role_seq.sv
module i2c_role_seq
    import i2c_role_pkg::*;
#(
    parameter int QTR_DIV = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic              rd_nwr,
    input  logic [ADR_W-1:0]  tgt_addr,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic [ADR_W-1:0]  own_addr,
    input  logic [BYTE_W-1:0] slv_tx_byte,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_oe,
    output logic              sda_oe,
    output logic              is_master,
    output logic              bus_busy,
    output logic              xfer_done,
    output logic              nack_err,
    output logic [BYTE_W-1:0] rx_byte
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    role_state_e       state;
    role_state_e       nstate;
    bus_evt_t          evt;
    logic              tick;
    logic              m_act;
    logic              accept;
    logic              m_end;
    logic              m_smp;
    logic              addr_hit;
    logic [1:0]        q;
    logic [BYTE_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              rw_q;
    logic              nack_q;
    logic              done_q;
    logic [BYTE_W-1:0] rx_q;

    i2c_line_watch u_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl_in),
        .sda_i (sda_in),
        .evt   (evt)
    );

    i2c_qtr_tick #(.DIV(QTR_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (m_act),
        .tick  (tick)
    );

    assign m_act    = in_master(state);
    assign accept   = (state == ST_S_IDLE) && start_req && !evt.busy;
    assign m_end    = tick && (q == 2'd3);
    assign m_smp    = tick && (q == 2'd2);
    assign addr_hit = (sh[BYTE_W-1:1] == own_addr);

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_S_IDLE: begin
                if (accept)         nstate = ST_M_START;
                else if (evt.start) nstate = ST_S_ADDR;
            end
            ST_S_ADDR: begin
                if (evt.scl_fall && cnt == ALL_BITS)
                    nstate = addr_hit ? ST_S_AACK : ST_S_SKIP;
            end
            ST_S_AACK: begin
                if (evt.scl_fall) nstate = rw_q ? ST_S_TX : ST_S_RX;
            end
            ST_S_RX: begin
                if (evt.scl_fall && cnt == ALL_BITS) nstate = ST_S_RACK;
            end
            ST_S_RACK: begin
                if (evt.scl_fall) nstate = ST_S_WSTOP;
            end
            ST_S_TX: begin
                if (evt.scl_fall && cnt == LAST_BIT) nstate = ST_S_TACK;
            end
            ST_S_TACK: begin
                if (evt.scl_fall) nstate = ST_S_WSTOP;
            end
            ST_S_WSTOP, ST_S_SKIP: begin
                nstate = state;
            end
            ST_M_START: begin
                if (m_end) nstate = ST_M_ADDR;
            end
            ST_M_ADDR: begin
                if (m_end && cnt == LAST_BIT) nstate = ST_M_AACK;
            end
            ST_M_AACK: begin
                if (m_end) nstate = nack_q ? ST_M_STOP : ST_M_DATA;
            end
            ST_M_DATA: begin
                if (m_end && cnt == LAST_BIT) nstate = ST_M_DACK;
            end
            ST_M_DACK: begin
                if (m_end) nstate = ST_M_STOP;
            end
            ST_M_STOP: begin
                if (m_end) nstate = ST_S_IDLE;
            end
            default: nstate = ST_S_IDLE;
        endcase
        // A stop or a repeated start overrides any active target state.
        if (!m_act && state != ST_S_IDLE) begin
            if (evt.stop)       nstate = ST_S_IDLE;
            else if (evt.start) nstate = ST_S_ADDR;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_S_IDLE;
        else        state <= nstate;
    end

    // Shift, count and flag registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            sh     <= '0;
            cnt    <= '0;
            rw_q   <= 1'b0;
            nack_q <= 1'b0;
            done_q <= 1'b0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (m_act && tick) q <= q + 2'd1;
            unique case (state)
                ST_S_IDLE: begin
                    if (accept) begin
                        sh     <= {tgt_addr, rd_nwr};
                        rw_q   <= rd_nwr;
                        cnt    <= '0;
                        q      <= '0;
                        nack_q <= 1'b0;
                    end else if (evt.start) begin
                        cnt <= '0;
                    end
                end
                ST_S_ADDR, ST_S_RX: begin
                    if (evt.scl_rise) begin
                        sh  <= {sh[BYTE_W-2:0], sda_in};
                        cnt <= cnt + CNT_W'(1);
                    end
                    if (evt.scl_fall && cnt == ALL_BITS) begin
                        cnt <= '0;
                        if (state == ST_S_ADDR) rw_q <= sh[0];
                        else                    rx_q <= sh;
                    end
                end
                ST_S_AACK: begin
                    if (evt.scl_fall) begin
                        cnt <= '0;
                        if (rw_q) sh <= slv_tx_byte;
                    end
                end
                ST_S_TX: begin
                    if (evt.scl_fall) begin
                        sh  <= {sh[BYTE_W-2:0], 1'b0};
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_S_WSTOP: begin
                    if (evt.stop) done_q <= 1'b1;
                end
                ST_M_ADDR: begin
                    if (m_end) begin
                        sh  <= {sh[BYTE_W-2:0], 1'b0};
                        cnt <= (cnt == LAST_BIT) ? '0 : cnt + CNT_W'(1);
                    end
                end
                ST_M_AACK: begin
                    if (m_smp && sda_in) nack_q <= 1'b1;
                    if (m_end && !rw_q)  sh <= wr_byte;
                end
                ST_M_DATA: begin
                    if (m_smp && rw_q) sh <= {sh[BYTE_W-2:0], sda_in};
                    if (m_end) begin
                        if (!rw_q) sh <= {sh[BYTE_W-2:0], 1'b0};
                        if (cnt == LAST_BIT) begin
                            cnt <= '0;
                            if (rw_q) rx_q <= sh;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                end
                ST_M_DACK: begin
                    if (m_smp && !rw_q && sda_in) nack_q <= 1'b1;
                end
                ST_M_STOP: begin
                    if (m_end) done_q <= 1'b1;
                end
                default: ;
            endcase
            if (!m_act && state != ST_S_IDLE && evt.start) cnt <= '0;
        end
    end

    // Line drive: only pull low or release
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            ST_M_START: begin
                scl_oe = q[1];
                sda_oe = 1'b1;
            end
            ST_M_ADDR: begin
                scl_oe = !q[1];
                sda_oe = !sh[BYTE_W-1];
            end
            ST_M_AACK, ST_M_DACK: begin
                scl_oe = !q[1];
            end
            ST_M_DATA: begin
                scl_oe = !q[1];
                sda_oe = !rw_q && !sh[BYTE_W-1];
            end
            ST_M_STOP: begin
                scl_oe = !q[1];
                sda_oe = (q != 2'd3);
            end
            ST_S_AACK, ST_S_RACK: begin
                sda_oe = 1'b1;
            end
            ST_S_TX: begin
                sda_oe = !sh[BYTE_W-1];
            end
            default: ;
        endcase
    end

    assign is_master = m_act;
    assign bus_busy  = evt.busy;
    assign xfer_done = done_q;
    assign nack_err  = nack_q;
    assign rx_byte   = rx_q;

endmodule

// File: rtl/i2c_role_seq_chk.sv
module i2c_role_seq_chk
    import i2c_role_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        start_req,
    input logic        is_master,
    input logic        bus_busy,
    input logic        xfer_done,
    input logic        nack_err,
    input logic        scl_in,
    input logic        sda_in,
    input role_state_e state
);

    a_r1_target_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !is_master);

    a_r2_enter_master: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_S_IDLE && start_req && !bus_busy) |=> is_master);

    a_r3_leave_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(is_master) && !is_master) |-> xfer_done);

    a_r4_addr_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_M_ADDR) |-> ($past(state) == ST_M_START || $past(state) == ST_M_ADDR));

    a_r6_busy_blocks_request: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && bus_busy && !is_master) |=> !is_master);

    a_r7_no_data_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_M_DATA) |-> !nack_err);

    a_r9_start_marks_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_in && $past(scl_in) && $fell(sda_in)) |=> bus_busy);

endmodule

bind i2c_role_seq i2c_role_seq_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_req (start_req),
    .is_master (is_master),
    .bus_busy  (bus_busy),
    .xfer_done (xfer_done),
    .nack_err  (nack_err),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .state     (state)
);

// File: tb/i2c_role_seq_tb.sv
`timescale 1ns/1ps
module i2c_role_seq_tb_top;

    localparam int QD = 4;
    localparam int HT = 40;
    localparam logic [6:0] OWN = 7'h3A;
    localparam logic [6:0] REMOTE = 7'h51;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n;
    logic       start_req;
    logic       rd_nwr;
    logic [6:0] tgt_addr;
    logic [7:0] wr_byte;
    logic [6:0] own_addr;
    logic [7:0] slv_tx_byte;
    logic       tb_scl_low;
    logic       tb_sda_low;
    wire        scl_w;
    wire        sda_w;
    logic       scl_oe;
    logic       sda_oe;
    logic       is_master;
    logic       bus_busy;
    logic       xfer_done;
    logic       nack_err;
    logic [7:0] rx_byte;

    assign scl_w = !(scl_oe || tb_scl_low);
    assign sda_w = !(sda_oe || tb_sda_low);

    i2c_role_seq #(.QTR_DIV(QD)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .rd_nwr(rd_nwr),
        .tgt_addr(tgt_addr), .wr_byte(wr_byte), .own_addr(own_addr),
        .slv_tx_byte(slv_tx_byte), .scl_in(scl_w), .sda_in(sda_w),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .is_master(is_master),
        .bus_busy(bus_busy), .xfer_done(xfer_done), .nack_err(nack_err),
        .rx_byte(rx_byte)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int done_cnt = 0;

    always @(posedge clk) if (rst_n && xfer_done) done_cnt = done_cnt + 1;

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_m_nack(input logic [6:0] a, input logic rw, input logic ackd);
        return (a != REMOTE) || (!rw && !ackd);
    endfunction

    // Remote target model for master-mode frames
    task automatic bslave(input logic ack_d, input logic [7:0] tx,
                          output logic [7:0] got_a, output logic [7:0] got_d);
        logic [7:0] a;
        logic [7:0] d;
        logic hit;
        a = '0;
        d = '0;
        forever begin
            @(negedge sda_w);
            if (scl_w) break;
        end
        for (int i = 0; i < 8; i++) begin
            @(posedge scl_w);
            a = {a[6:0], sda_w};
        end
        hit = (a[7:1] == REMOTE);
        @(negedge scl_w); #1; tb_sda_low = hit;
        @(negedge scl_w); #1; tb_sda_low = 1'b0;
        if (hit && !a[0]) begin
            for (int i = 0; i < 8; i++) begin
                @(posedge scl_w);
                d = {d[6:0], sda_w};
            end
            @(negedge scl_w); #1; tb_sda_low = ack_d;
            @(negedge scl_w); #1; tb_sda_low = 1'b0;
        end else if (hit) begin
            for (int i = 0; i < 8; i++) begin
                tb_sda_low = !tx[3'(7 - i)];
                @(negedge scl_w); #1;
            end
            tb_sda_low = 1'b0;
        end
        got_a = a;
        got_d = d;
    endtask

    task automatic m_run(input logic rw, input logic [6:0] a, input logic [7:0] wd,
                         input logic ack_d, input logic [7:0] tx);
        logic [7:0] ga;
        logic [7:0] gd;
        int d0;
        bit en;
        tgt_addr = a;
        rd_nwr = rw;
        wr_byte = wd;
        d0 = done_cnt;
        en = exp_m_nack(a, rw, ack_d);
        fork
            bslave(ack_d, tx, ga, gd);
            begin
                @(negedge clk); start_req = 1'b1;
                @(negedge clk); start_req = 1'b0;
                chk("R2 is_master after request", int'(is_master), 1);
            end
        join
        wait (is_master == 1'b0);
        repeat (3) @(negedge clk);
        chk("R3 one done pulse after master stop", done_cnt - d0, 1);
        chk("R4 address byte on bus", int'(ga), int'({a, rw}));
        chk("R7 nack flag", int'(nack_err), int'(en));
        if (a == REMOTE && !rw) chk("R5 written byte", int'(gd), int'(wd));
        if (a == REMOTE && rw)  chk("R5 read byte", int'(rx_byte), int'(tx));
        chk("R9 bus free after stop", int'(bus_busy), 0);
    endtask

    // Remote master model for target-mode frames
    task automatic bm_bit(input logic b, output logic r);
        tb_sda_low = !b;
        #HT; tb_scl_low = 1'b0;
        #HT; r = sda_w; tb_scl_low = 1'b1;
    endtask

    task automatic s_run(input logic [6:0] a, input logic rw, input logic [7:0] wd);
        logic r;
        logic ack_a;
        logic ack_d;
        logic [7:0] rd;
        int d0;
        bit hit;
        hit = (a == OWN);
        d0 = done_cnt;
        rd = '0;
        ack_d = 1'b0;
        @(negedge clk);
        tb_sda_low = 1'b1; #HT; tb_scl_low = 1'b1;
        for (int i = 0; i < 8; i++) bm_bit(i < 7 ? a[3'(6 - i)] : rw, r);
        bm_bit(1'b1, r);
        ack_a = !r;
        if (ack_a && !rw) begin
            for (int i = 0; i < 8; i++) bm_bit(wd[3'(7 - i)], r);
            bm_bit(1'b1, r);
            ack_d = !r;
        end else if (ack_a) begin
            for (int i = 0; i < 8; i++) begin
                bm_bit(1'b1, r);
                rd = {rd[6:0], r};
            end
            bm_bit(1'b1, r);
        end
        tb_sda_low = 1'b1; #HT; tb_scl_low = 1'b0; #HT; tb_sda_low = 1'b0; #HT;
        repeat (3) @(negedge clk);
        chk("R10 address acknowledge", int'(ack_a), int'(hit));
        chk("R10 done count for target frame", done_cnt - d0, hit ? 1 : 0);
        if (hit && !rw) begin
            chk("R11 byte acknowledged", int'(ack_d), 1);
            chk("R11 rx_byte", int'(rx_byte), int'(wd));
        end
        if (hit && rw) chk("R12 byte returned", int'(rd), int'(slv_tx_byte));
        chk("R1 stays target in target frame", int'(is_master), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int seed;
        seed = int'($urandom(32'd20240517));
        rst_n = 1'b0;
        start_req = 1'b0;
        rd_nwr = 1'b0;
        tgt_addr = '0;
        wr_byte = '0;
        own_addr = OWN;
        slv_tx_byte = 8'hC5;
        tb_scl_low = 1'b0;
        tb_sda_low = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 is_master after reset", int'(is_master), 0);
        chk("R1 scl_oe after reset", int'(scl_oe), 0);
        chk("R1 sda_oe after reset", int'(sda_oe), 0);
        chk("R1 bus_busy after reset", int'(bus_busy), 0);
        chk("R1 nack_err after reset", int'(nack_err), 0);
        chk("R8 released scl reads high", int'(scl_w), 1);
        chk("R8 released sda reads high", int'(sda_w), 1);

        // Directed master frames
        m_run(1'b0, REMOTE, 8'hA6, 1'b1, 8'h00);
        m_run(1'b1, REMOTE, 8'h00, 1'b1, 8'h3C);
        m_run(1'b0, 7'h22, 8'h5A, 1'b1, 8'h00);   // address NACK, R7
        m_run(1'b0, REMOTE, 8'hF0, 1'b0, 8'h00);  // data NACK, R7
        m_run(1'b1, REMOTE, 8'h00, 1'b1, 8'h81);  // R7 flag cleared

        // Busy bus blocks a start request
        @(negedge clk);
        tb_sda_low = 1'b1;
        #HT;
        chk("R9 busy after start", int'(bus_busy), 1);
        @(negedge clk); start_req = 1'b1;
        @(negedge clk); start_req = 1'b0;
        chk("R6 request ignored while busy", int'(is_master), 0);
        repeat (6) @(negedge clk);
        chk("R6 still target later", int'(is_master), 0);
        chk("R8 remote pulls sda low", int'(sda_w), 0);
        tb_scl_low = 1'b1; #HT;
        tb_scl_low = 1'b0; #HT;
        tb_sda_low = 1'b0; #HT;
        chk("R9 free after stop", int'(bus_busy), 0);

        // Directed target frames
        s_run(OWN, 1'b0, 8'h96);
        s_run(OWN, 1'b1, 8'h00);
        s_run(7'h12, 1'b0, 8'h44);

        // Random frames
        for (int k = 0; k < 8; k++) begin
            logic rw;
            logic [6:0] a;
            logic [7:0] d;
            logic [7:0] t;
            rw = 1'($urandom % 2);
            a = ($urandom % 4 == 0) ? 7'($urandom) : REMOTE;
            d = 8'($urandom);
            t = 8'($urandom);
            m_run(rw, a, d, 1'($urandom % 4 != 0), t);
        end
        for (int k = 0; k < 8; k++) begin
            logic rw;
            logic [6:0] a;
            rw = 1'($urandom % 2);
            a = ($urandom % 4 == 0) ? 7'($urandom) : OWN;
            slv_tx_byte = 8'($urandom);
            s_run(a, rw, 8'($urandom));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule